// File: doc/BRIEF.md
# Staggered Two-Door Timed Opener

A momentary request button starts a one-shot timing run that powers two doors with overlapping windows. The first door is powered from the start of the run. The second door is powered from a later instant until the end of the run. The first door's power drops before the run ends. All instants are counted from the same start point, so the windows stay fixed relative to one another.

The button is synchronised and edge-detected. Only a fresh press, seen while the opener is idle, starts a run. Time advances only on a one-cycle time-base tick supplied from outside, so one tick can stand for any period (1 ms, 100 ms, 1 s). A single shared counter measures the elapsed ticks. The run latch releases itself on the final tick, which also returns the counter to zero.

Top module: `door_opener_seq`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `busy_o`, `door1_o` and `door2_o` are all 0. A reset during a run aborts the run.
- R2: A press is a 0-to-1 change of the synchronised button. A press seen while idle sets `busy_o` and `door1_o` to 1, with `door2_o` still 0, on the clock edge `SYNC_STAGES+1` edges after `btn_i` rises.
- R3: `door1_o` stays 1 until the edge that counts the `D1_OFF_TICKS`-th tick of the run, and is 0 from that edge on.
- R4: `door2_o` becomes 1 on the edge that counts the `D2_ON_TICKS`-th tick. It becomes 0 on the edge that counts the `END_TICKS`-th tick. It is never 1 while `busy_o` is 0.
- R5: On the edge that counts the `END_TICKS`-th tick, `busy_o` and both door outputs fall together to 0.
- R6: A press made while a run is in progress has no effect. This includes a press that lands on the cycle of the final tick: the run is neither restarted nor extended, and the opener is idle afterwards.
- R7: A button held high starts at most one run. It must return low before it can start another, and a button already high when reset ends starts nothing.
- R8: Ticks while idle are ignored. A press after a run has ended starts a fresh run with the full window timing.
- R9: Between ticks all three outputs hold their values; only the tick advances the elapsed count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle time-base pulse |
| btn_i | input | 1 | Request button level (momentary) |
| door1_o | output | 1 | First door power, registered |
| door2_o | output | 1 | Second door power, registered |
| busy_o | output | 1 | High while a run is in progress, registered |

## Verification
A rising button reaches the outputs `SYNC_STAGES+1` edges later: three edges with the default two-stage synchroniser. A tick changes the outputs on the very edge that samples it, because the door registers load from the next-state count. The bench drives and samples on the falling clock edge. Each stimulus row is therefore checked against the state after exactly one rising edge, and the expected button response is placed two rows after the row that raises the button. The directed cases line a press up with the final tick, hold the button across a whole run, and reset in mid-run.

// File: rtl/door_seq_pkg.sv
package door_seq_pkg;

  // Bits needed to hold values 0..max_val, at least one.
  function automatic int cnt_bits(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

endpackage

// File: rtl/dso_press_detect.sv
module dso_press_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_i,
  output logic press_o
);

  logic btn_s;
  logic prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign btn_s = btn_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      // Reset to 1 so that a button held through reset is not a press.
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], btn_i} & {SYNC_STAGES{1'b1}};
      end
      assign btn_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= btn_s;
  end

  assign press_o = btn_s & ~prev_q;

  AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    press_o |=> !press_o); // R7

endmodule

// File: rtl/dso_run_timer.sv
module dso_run_timer #(
  parameter int CW        = 4,
  parameter int END_TICKS = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          tick_i,
  output logic          run_o,
  output logic          run_nxt_o,
  output logic [CW-1:0] cnt_nxt_o
);

  localparam logic [CW-1:0] LAST = CW'(END_TICKS - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic          run_n;
  logic [CW-1:0] cnt_n;

  always_comb begin
    run_n = run_q;
    cnt_n = cnt_q;
    if (!run_q) begin
      if (start_i) begin
        run_n = 1'b1;
        cnt_n = '0;
      end
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        run_n = 1'b0;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_n;
      cnt_q <= cnt_n;
    end
  end

  assign run_o     = run_q;
  assign run_nxt_o = run_n;
  assign cnt_nxt_o = cnt_n;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> cnt_q == '0); // R8
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (run_q && !tick_i) |=> (run_q && $stable(cnt_q))); // R9
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (run_q && start_i && !tick_i) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/dso_window_out.sv
module dso_window_out #(
  parameter int CW     = 4,
  parameter int ON_AT  = 0,
  parameter int OFF_AT = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_nxt_i,
  input  logic [CW-1:0] cnt_nxt_i,
  output logic          door_o
);

  localparam logic [CW-1:0] OFF_W = CW'(OFF_AT);

  logic lo_ok;

  generate
    if (ON_AT == 0) begin : g_from_start
      assign lo_ok = 1'b1;
    end else begin : g_delayed
      localparam logic [CW-1:0] ON_W = CW'(ON_AT);
      assign lo_ok = (cnt_nxt_i >= ON_W);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) door_o <= 1'b0;
    else     door_o <= run_nxt_i & lo_ok & (cnt_nxt_i < OFF_W);
  end

endmodule

// File: rtl/door_opener_seq.sv
module door_opener_seq
  import door_seq_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int D2_ON_TICKS  = 2,
  parameter int D1_OFF_TICKS = 10,
  parameter int END_TICKS    = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic btn_i,
  output logic door1_o,
  output logic door2_o,
  output logic busy_o
);

  localparam int CW     = cnt_bits(END_TICKS);
  localparam int NDOORS = 2;

  logic          press_w;
  logic          run_w;
  logic          run_nxt_w;
  logic [CW-1:0] cnt_nxt_w;
  logic [NDOORS-1:0] door_w;

  dso_press_detect #(.SYNC_STAGES(SYNC_STAGES)) i_press (
    .clk     (clk),
    .rst     (rst),
    .btn_i   (btn_i),
    .press_o (press_w)
  );

  dso_run_timer #(.CW(CW), .END_TICKS(END_TICKS)) i_timer (
    .clk       (clk),
    .rst       (rst),
    .start_i   (press_w),
    .tick_i    (tick_i),
    .run_o     (run_w),
    .run_nxt_o (run_nxt_w),
    .cnt_nxt_o (cnt_nxt_w)
  );

  // Door 0 window [0, D1_OFF), door 1 window [D2_ON, END).
  for (genvar g = 0; g < NDOORS; g++) begin : g_door
    dso_window_out #(
      .CW     (CW),
      .ON_AT  (g == 0 ? 0 : D2_ON_TICKS),
      .OFF_AT (g == 0 ? D1_OFF_TICKS : END_TICKS)
    ) i_win (
      .clk       (clk),
      .rst       (rst),
      .run_nxt_i (run_nxt_w),
      .cnt_nxt_i (cnt_nxt_w),
      .door_o    (door_w[g])
    );
  end

  assign door1_o = door_w[0];
  assign door2_o = door_w[1];
  assign busy_o  = run_w;

  AST_START_RESP: assert property (@(posedge clk) disable iff (rst)
    (press_w && !busy_o) |=> (busy_o && door1_o)); // R2
  AST_D1_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    door1_o |-> busy_o); // R3
  AST_D2_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    door2_o |-> busy_o); // R4
  AST_END_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (!door1_o && !door2_o)); // R5

  generate
    if (D2_ON_TICKS > 0) begin : g_stagger_chk
      AST_D2_LATE: assert property (@(posedge clk) disable iff (rst)
        $rose(door2_o) |-> (busy_o && $past(busy_o))); // R4
    end
  endgenerate

endmodule

// File: tb/test_door_opener_seq.sv
module test_door_opener_seq;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic btn_i = 1'b0;
  logic door1_o, door2_o, busy_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  door_opener_seq i_door_opener_seq (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .btn_i   (btn_i),
    .door1_o (door1_o),
    .door2_o (door2_o),
    .busy_o  (busy_o)
  );

  // Row: {btn, tick, exp_busy, exp_door1, exp_door2}; expected values are
  // the state after the rising edge that follows the row being driven.
  localparam int NROWS = 20;
  localparam logic [4:0] VEC [NROWS] = '{
    5'b10_000, // press raised
    5'b10_000,
    5'b00_110, // R2: busy and door1, door2 still off
    5'b01_110, // tick 1
    5'b01_111, // tick 2: R4 door2 on
    5'b00_111, // no tick: R9 hold
    5'b11_111, // tick 3, second press raised (R6)
    5'b01_111, // tick 4
    5'b01_111, // tick 5, press ignored
    5'b01_111, // tick 6
    5'b01_111, // tick 7
    5'b01_111, // tick 8
    5'b01_111, // tick 9
    5'b01_101, // tick 10: R3 door1 off
    5'b01_101, // tick 11
    5'b01_101, // tick 12
    5'b01_101, // tick 13
    5'b01_000, // tick 14: R5 end
    5'b01_000, // idle tick: R8
    5'b00_000
  };

  task automatic drive(input logic b, input logic t);
    btn_i  = b;
    tick_i = t;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {busy_o, door1_o, door2_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: busy/door1/door2 got %b expected %b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n, input logic b);
    for (int k = 0; k < n; k++) drive(b, 1'b1);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 in reset", 3'b000);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) drive(1'b0, 1'b0);
    check("R1 after reset", 3'b000);

    // Table walk: R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < NROWS; i++) begin
      drive(VEC[i][4], VEC[i][3]);
      check($sformatf("table row %0d (R2 R3 R4 R5 R6 R9)", i), VEC[i][2:0]);
    end

    // R7: button held across a whole run starts only one run
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b0);
    check("R7 held start", 3'b110);
    ticks(14, 1'b1);
    check("R7 held end", 3'b000);
    for (int k = 0; k < 4; k++) drive(1'b1, 1'b0);
    check("R7 held no restart", 3'b000);

    // R8: release, press again, fresh run with full timing
    for (int k = 0; k < 3; k++) drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    check("R8 fresh start", 3'b110);
    ticks(1, 1'b0);
    check("R8 fresh tick1", 3'b110);
    ticks(1, 1'b0);
    check("R8 fresh tick2 door2", 3'b111);
    ticks(7, 1'b0);
    check("R8 fresh tick9", 3'b111);
    ticks(1, 1'b0);
    check("R8 fresh tick10 door1 off", 3'b101);
    ticks(4, 1'b0);
    check("R8 fresh end", 3'b000);

    // R6: press that lands on the final-tick cycle is ignored
    for (int k = 0; k < 3; k++) drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b0);
    check("R6 setup start", 3'b110);
    for (int k = 0; k < 3; k++) drive(1'b0, 1'b0);
    ticks(13, 1'b0);
    check("R6 before final tick", 3'b101);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    check("R6 final tick with press", 3'b000);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    check("R6 no restart after end", 3'b000);

    // R1: reset aborts a run
    for (int k = 0; k < 3; k++) drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b0);
    ticks(3, 1'b0);
    check("R1 pre-abort", 3'b111);
    rst = 1'b1;
    drive(1'b0, 1'b0);
    check("R1 abort", 3'b000);
    rst = 1'b0;
    ticks(3, 1'b0);
    check("R1 stays idle", 3'b000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule